// File: doc/BRIEF.md
# Fractional Rate Divider with Control Register

This block turns a free-running input clock into a one-cycle-wide enable pulse (`tick_o`). The average rate of that pulse is the input rate divided by a programmable ratio, and the ratio can step in fractions of a cycle. The ratio is held in a divisor field of `FIELD_W` bits inside a 32-bit control register. The field starts at bit `FIELD_LSB`. Its lowest `FRAC_W` bits are fractional, so the ratio is (field + 2^FRAC_W) / 2^FRAC_W. A field value of zero therefore means divide-by-one. Internally a phase accumulator adds 2^FRAC_W on every cycle. Whenever the sum reaches the period, the block emits a tick and subtracts the period.

The register has two write paths. The whole-register write replaces all 32 bits. The divisor write is a read-modify-write that touches only the field and the flag bits tied to the chosen variant. Three variants are available. The plain variant has no extra bits. The serial-port variant keeps bit 24 as a divider-enable flag that follows whether the written divisor is nonzero; while bit 24 is clear, the divider is bypassed. The fixed variant sets an override bit six places below the field on every divisor write. A new divisor is adopted only at an output period boundary.

Top module: `frac_rate_divider`

## Requirements
- R1: While `rst_n` is low the register clears to zero and `tick_o` is low. After release, a zero field gives a tick on every cycle.
- R2: With field value D and P = D + 2^FRAC_W, once the divisor has settled any window of k·P consecutive cycles holds exactly k·2^FRAC_W ticks.
- R3: A field value of 0 gives a tick on every cycle (divide-by-one).
- R4: The largest field value, 2^FIELD_W − 1, is accepted and divides by (2^FIELD_W − 1 + 2^FRAC_W) / 2^FRAC_W.
- R5: A divisor write changes only bits [FIELD_LSB+FIELD_W−1 : FIELD_LSB] and the variant's flag bit. Every other register bit keeps its value.
- R6: In the serial-port variant, a divisor write sets register bit 24 when the written value is nonzero and clears it when the value is zero.
- R7: In the serial-port variant, while register bit 24 is 0 the divider is bypassed and `tick_o` is high on every cycle, whatever the field holds.
- R8: In the fixed variant, every divisor write sets register bit FIELD_LSB − 6, whatever value is written.
- R9: A new divisor takes effect only at the next tick of the old period. When not bypassed, the adopted divisor changes only in a cycle where `tick_o` is high.
- R10: `rd_data` always shows the full 32-bit register.
- R11: A whole-register write replaces all 32 bits. If it coincides with a divisor write, the divisor write's changes are applied on top of the written word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Replace the whole control register |
| reg_wr_data | input | 32 | Word for the whole-register write |
| div_wr_en | input | 1 | Read-modify-write of the divisor field |
| div_wr_val | input | FIELD_W | New divisor field value |
| rd_data | output | 32 | Current control register |
| tick_o | output | 1 | Divided-rate enable pulse |

## Verification
The rate is measured over whole multiples of the period for several divisors:
- The unity field shows that zero means divide-by-one.
- The smallest fractional step (one input cycle of 1.5) shows that the fraction is applied rather than truncated.
- Odd integer-plus-half values show that the residue is carried between periods.
- The maximum field shows that the top of the range does not overflow.

Register traffic mixes whole-register writes, divisor writes and both at once. This separates the preserved bits from the rewritten ones and shows the serial-port enable flag following the value. A divisor written just after a tick, followed by a quiet window, tells a boundary-aligned update from an immediate one. A second instance in the fixed variant covers the override bit.

// File: rtl/fdiv_pkg.sv
// Package: shared variant type and register layout constants for the
// fractional rate divider. Assumes the field fits in 32 bits.
package fdiv_pkg;

    typedef enum logic [1:0] {
        FDIV_PLAIN = 2'd0,
        FDIV_UART  = 2'd1,
        FDIV_FIXED = 2'd2
    } fdiv_variant_e;

    localparam int unsigned REG_W       = 32;
    localparam int unsigned UART_EN_BIT = 24;
    localparam int unsigned OVR_DIST    = 6;

    // Mask with ones over a field of width w starting at bit lsb.
    function automatic logic [REG_W-1:0] field_mask(int unsigned w, int unsigned lsb);
        logic [63:0] m;
        m = ((64'd1 << w) - 64'd1) << lsb;
        return m[REG_W-1:0];
    endfunction

endpackage

// File: rtl/fdiv_ctrl_reg.sv
// Control register of the divider. It offers a whole-word write and a
// read-modify-write divisor update, and adds the variant's flag bit.
// Assumes FIELD_LSB + FIELD_W <= 32 and, for the fixed variant, FIELD_LSB >= 6.
module fdiv_ctrl_reg
    import fdiv_pkg::*;
#(
    parameter int unsigned   FIELD_W   = 8,
    parameter int unsigned   FIELD_LSB = 8,
    parameter fdiv_variant_e VARIANT   = FDIV_UART
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [REG_W-1:0]   reg_wr_data,
    input  logic               div_wr_en,
    input  logic [FIELD_W-1:0] div_wr_val,
    output logic [REG_W-1:0]   ctrl_q,
    output logic [FIELD_W-1:0] field,
    output logic               bypass
);
    localparam logic [REG_W-1:0] FMASK   = field_mask(FIELD_W, FIELD_LSB);
    localparam int unsigned      OVR_BIT = (FIELD_LSB >= OVR_DIST) ? FIELD_LSB - OVR_DIST : 0;

    logic [REG_W-1:0] ctrl_d;

    // Next register value: whole-word write first, divisor merge on top.
    always_comb begin
        ctrl_d = reg_wr_en ? reg_wr_data : ctrl_q;
        if (div_wr_en) begin
            ctrl_d = (ctrl_d & ~FMASK) | (REG_W'(div_wr_val) << FIELD_LSB);
            if (VARIANT == FDIV_UART)  ctrl_d[UART_EN_BIT] = |div_wr_val;
            if (VARIANT == FDIV_FIXED) ctrl_d[OVR_BIT]     = 1'b1;
        end
    end

    // Register storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    // Field extraction and the bypass decode of the serial-port variant.
    always_comb begin
        field  = ctrl_q[FIELD_LSB +: FIELD_W];
        bypass = (VARIANT == FDIV_UART) ? !ctrl_q[UART_EN_BIT] : 1'b0;
    end

endmodule

// File: rtl/fdiv_phase_acc.sv
// Phase accumulator. It adds 2^FRAC_W per cycle and emits a tick when the sum
// reaches (divisor + 2^FRAC_W). A new divisor is adopted only on a tick, and
// the phase restarts from zero when the divisor changes.
// Assumes new_field is stable except when software writes it.
module fdiv_phase_acc #(
    parameter int unsigned FIELD_W = 8,
    parameter int unsigned FRAC_W  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bypass,
    input  logic [FIELD_W-1:0] new_field,
    output logic               tick,
    output logic [FIELD_W-1:0] act_field
);
    localparam int unsigned ACC_W = ((FIELD_W > FRAC_W) ? FIELD_W : FRAC_W) + 2;
    localparam logic [ACC_W-1:0] STEP = ACC_W'(1) << FRAC_W;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] period;
    logic [ACC_W-1:0] sum;
    logic             hit;

    // Period of the adopted divisor and this cycle's accumulator sum.
    always_comb begin
        period = ACC_W'(act_field) + STEP;
        sum    = acc_q + STEP;
        hit    = (sum >= period);
    end

    // Accumulator update, tick generation and boundary-aligned reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            act_field <= '0;
            tick      <= 1'b0;
        end else if (bypass) begin
            acc_q     <= '0;
            act_field <= new_field;
            tick      <= 1'b1;
        end else begin
            tick <= hit;
            if (hit) begin
                act_field <= new_field;
                acc_q     <= (new_field != act_field) ? '0 : sum - period;
            end else begin
                acc_q <= sum;
            end
        end
    end

endmodule

// File: rtl/frac_rate_divider.sv
// Top level of the fractional rate divider. The control register feeds the
// phase accumulator. tick_o is registered, so it follows the register by one cycle.
module frac_rate_divider
    import fdiv_pkg::*;
#(
    parameter int unsigned   FIELD_W   = 8,
    parameter int unsigned   FRAC_W    = 1,
    parameter int unsigned   FIELD_LSB = 8,
    parameter fdiv_variant_e VARIANT   = FDIV_UART
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [31:0]        reg_wr_data,
    input  logic               div_wr_en,
    input  logic [FIELD_W-1:0] div_wr_val,
    output logic [31:0]        rd_data,
    output logic               tick_o
);
    logic [REG_W-1:0]   ctrl_q;
    logic [FIELD_W-1:0] field;
    logic               bypass;
    logic [FIELD_W-1:0] act_field;

    fdiv_ctrl_reg #(
        .FIELD_W  (FIELD_W),
        .FIELD_LSB(FIELD_LSB),
        .VARIANT  (VARIANT)
    ) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr_en  (reg_wr_en),
        .reg_wr_data(reg_wr_data),
        .div_wr_en  (div_wr_en),
        .div_wr_val (div_wr_val),
        .ctrl_q     (ctrl_q),
        .field      (field),
        .bypass     (bypass)
    );

    fdiv_phase_acc #(
        .FIELD_W(FIELD_W),
        .FRAC_W (FRAC_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .bypass   (bypass),
        .new_field(field),
        .tick     (tick_o),
        .act_field(act_field)
    );

    // Read path: the full register, unchanged.
    always_comb rd_data = ctrl_q;

endmodule

// File: rtl/fdiv_checker.sv
// Checker for the fractional rate divider. It is bound into every instance
// and relates the register, the adopted divisor and the tick output over time.
module fdiv_checker
    import fdiv_pkg::*;
#(
    parameter int unsigned   FIELD_W   = 8,
    parameter int unsigned   FIELD_LSB = 8,
    parameter fdiv_variant_e VARIANT   = FDIV_UART
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr_en,
    input logic               div_wr_en,
    input logic [FIELD_W-1:0] div_wr_val,
    input logic [31:0]        rd_data,
    input logic               tick_o,
    input logic [FIELD_W-1:0] act_field
);
    localparam int unsigned OVR_BIT = (FIELD_LSB >= OVR_DIST) ? FIELD_LSB - OVR_DIST : 0;
    localparam logic [31:0] FLAG = (VARIANT == FDIV_UART)  ? (32'h1 << UART_EN_BIT) :
                                   (VARIANT == FDIV_FIXED) ? (32'h1 << OVR_BIT) : 32'h0;
    localparam logic [31:0] KEEP = ~(field_mask(FIELD_W, FIELD_LSB) | FLAG);

    // R1: a cycle in reset leaves the register cleared.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (rd_data == 32'h0));

    // R5: a divisor-only write preserves every bit outside field and flag.
    a_r5_keep_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (div_wr_en && !reg_wr_en) |=> ((rd_data & KEEP) == ($past(rd_data) & KEEP)));

    // R9: the adopted divisor changes only alongside a tick.
    a_r9_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (act_field != $past(act_field)) |-> tick_o);

    if (VARIANT == FDIV_UART) begin : g_uart
        // R6: the enable flag follows whether the written divisor is nonzero.
        a_r6_uart_flag: assert property (@(posedge clk) disable iff (!rst_n)
            div_wr_en |=> (rd_data[UART_EN_BIT] == ($past(div_wr_val) != '0)));
        // R7: with the flag clear, the next cycle carries a tick.
        a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_data[UART_EN_BIT] |=> tick_o);
    end

    if (VARIANT == FDIV_FIXED) begin : g_fixed
        // R8: every divisor write leaves the override bit set.
        a_r8_override: assert property (@(posedge clk) disable iff (!rst_n)
            div_wr_en |=> rd_data[OVR_BIT]);
    end

endmodule

bind frac_rate_divider fdiv_checker #(
    .FIELD_W  (FIELD_W),
    .FIELD_LSB(FIELD_LSB),
    .VARIANT  (VARIANT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .div_wr_en (div_wr_en),
    .div_wr_val(div_wr_val),
    .rd_data   (rd_data),
    .tick_o    (tick_o),
    .act_field (act_field)
);

// File: tb/frac_rate_divider_tb.sv
`timescale 1ns/100ps
module frac_rate_divider_tb;
    import fdiv_pkg::*;

    localparam int W   = 8;
    localparam int F   = 1;
    localparam int LSB = 8;

    typedef struct {
        string       tag;
        logic [31:0] val;
    } item_t;

    item_t exp_q[$];
    item_t obs_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst_n = 1'b0;
    logic         a_rw = 1'b0, a_dw = 1'b0, f_rw = 1'b0, f_dw = 1'b0;
    logic [31:0]  a_rd_in = '0, f_rd_in = '0;
    logic [W-1:0] a_dv = '0, f_dv = '0;
    logic [31:0]  a_rd, f_rd;
    logic         a_tick, f_tick;

    frac_rate_divider #(.FIELD_W(W), .FRAC_W(F), .FIELD_LSB(LSB), .VARIANT(FDIV_UART)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(a_rw), .reg_wr_data(a_rd_in),
        .div_wr_en(a_dw), .div_wr_val(a_dv), .rd_data(a_rd), .tick_o(a_tick));

    frac_rate_divider #(.FIELD_W(W), .FRAC_W(F), .FIELD_LSB(LSB), .VARIANT(FDIV_FIXED)) u_dut_fx (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(f_rw), .reg_wr_data(f_rd_in),
        .div_wr_en(f_dw), .div_wr_val(f_dv), .rd_data(f_rd), .tick_o(f_tick));

    // Monitor: pop expected/observed pairs and compare them.
    always @(negedge clk) begin
        while (exp_q.size() > 0 && obs_q.size() > 0) begin
            item_t e;
            item_t o;
            e = exp_q.pop_front();
            o = obs_q.pop_front();
            checks++;
            if (e.val !== o.val) begin
                errors++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", e.tag, o.val, e.val);
            end
        end
    end

    task automatic push_exp(input string tag, input logic [31:0] v);
        exp_q.push_back('{tag, v});
    endtask

    task automatic push_obs(input string tag, input logic [31:0] v);
        obs_q.push_back('{tag, v});
    endtask

    // One write cycle on the chosen instance (fx=1 selects the fixed variant).
    task automatic do_write(input bit fx, input bit rw, input logic [31:0] word,
                            input bit dw, input logic [W-1:0] dv);
        @(negedge clk);
        if (fx) begin f_rw = rw; f_rd_in = word; f_dw = dw; f_dv = dv; end
        else    begin a_rw = rw; a_rd_in = word; a_dw = dw; a_dv = dv; end
        @(negedge clk);
        a_rw = 1'b0; a_dw = 1'b0; f_rw = 1'b0; f_dw = 1'b0;
    endtask

    task automatic chk_reg(input bit fx, input string tag, input logic [31:0] expv);
        push_exp(tag, expv);
        #1;
        push_obs(tag, fx ? f_rd : a_rd);
    endtask

    // Count ticks over len consecutive cycles, sampled just after the falling edge.
    task automatic chk_rate(input bit fx, input string tag, input int len, input int expn);
        int n = 0;
        push_exp(tag, 32'(expn));
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            #1;
            n += int'(fx ? f_tick : a_tick);
        end
        push_obs(tag, 32'(n));
    endtask

    task automatic settle();
        repeat (600) @(negedge clk);
    endtask

    // Driver: stimulus and expected values.
    initial begin
        repeat (3) @(negedge clk);
        chk_reg(0, "R1 reset register clear", 32'h0);
        chk_reg(1, "R1 reset register clear fixed", 32'h0);
        push_exp("R1 tick low in reset", 32'h0);
        #1 push_obs("R1 tick low in reset", 32'(a_tick | f_tick));
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk_rate(0, "R1 divide-by-one after reset", 20, 20);
        chk_rate(1, "R1 divide-by-one after reset fixed", 20, 20);

        // Ratio 1.5: period 3, two ticks each period.
        do_write(0, 0, '0, 1, 8'd1);
        chk_reg(0, "R6 flag set on nonzero / R10 read", 32'h0100_0100);
        settle();
        chk_rate(0, "R2 ratio 1.5", 12, 8);

        // Ratio 2.5: period 5.
        do_write(0, 0, '0, 1, 8'd3);
        settle();
        chk_rate(0, "R2 ratio 2.5", 20, 8);

        // Zero field: flag cleared, divide-by-one.
        do_write(0, 0, '0, 1, 8'd0);
        chk_reg(0, "R6 flag cleared on zero", 32'h0);
        settle();
        chk_rate(0, "R3 zero field every cycle", 16, 16);

        // Largest field: period 257.
        do_write(0, 0, '0, 1, 8'd255);
        chk_reg(0, "R4 max field register", 32'h0100_FF00);
        settle();
        chk_rate(0, "R4 max field rate", 514, 4);

        // Whole-word write, then a divisor merge over it.
        do_write(0, 1, 32'h5A00_003C, 0, '0);
        chk_reg(0, "R11 whole-word write", 32'h5A00_003C);
        do_write(0, 0, '0, 1, 8'd5);
        chk_reg(0, "R5 divisor merge keeps other bits", 32'h5B00_053C);
        settle();
        chk_rate(0, "R2 ratio 3.5", 21, 6);

        // Flag clear with nonzero field: bypass.
        do_write(0, 1, 32'h0000_0700, 0, '0);
        chk_reg(0, "R11 whole-word write field", 32'h0000_0700);
        repeat (2) @(negedge clk);
        chk_rate(0, "R7 bypass with flag clear", 10, 10);

        // Both write paths in one cycle.
        do_write(0, 1, 32'hFFFF_FFFF, 1, 8'd2);
        chk_reg(0, "R11 simultaneous writes", 32'hFFFF_02FF);

        // Boundary-aligned update: write just after a tick of a long period.
        do_write(0, 0, '0, 1, 8'd255);
        settle();
        do begin
            @(negedge clk);
            #1;
        end while (a_tick !== 1'b1);
        a_dw = 1'b1; a_dv = 8'd1;
        @(negedge clk);
        a_dw = 1'b0;
        chk_rate(0, "R9 old period kept until boundary", 100, 0);
        chk_reg(0, "R5 divisor update register", 32'hFFFF_01FF);
        settle();
        chk_rate(0, "R9 new ratio after boundary", 12, 8);

        // Fixed variant: override bit on every divisor write.
        do_write(1, 0, '0, 1, 8'd9);
        chk_reg(1, "R8 override set with divisor", 32'h0000_0904);
        settle();
        chk_rate(1, "R2 fixed ratio 5.5", 22, 4);
        do_write(1, 1, 32'h0, 0, '0);
        chk_reg(1, "R11 fixed whole-word clear", 32'h0);
        do_write(1, 0, '0, 1, 8'd0);
        chk_reg(1, "R8 override set with zero divisor", 32'h0000_0004);
        settle();
        chk_rate(1, "R3 fixed zero field", 8, 8);

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule